// File: doc/BRIEF.md
# DMA Register File

This block is the processor-facing register bank of a four-channel direct memory access controller. Software reaches it through a 4-bit register offset, a chip select, read and write strobes and an 8-bit data bus. Each channel has a 16-bit address pair and a 16-bit count pair, and each pair holds a base copy and a current copy. Because the bus is only one byte wide, these 16-bit values are moved one byte at a time. A single internal byte-pointer flip-flop, shared by all channels, decides which byte each access touches.

Around the channel words sit the global command register, a mode register for each channel, the request and mask bits, the terminal-count flags, the pending-request view and a temporary data byte. Several offsets serve as command strobes. When written, they clear the byte pointer, clear or load the masks, or perform a master clear. Some of them share an offset with a register that can be read. Every stored value is brought out as a flat vector for the separate transfer sequencer. That sequencer writes back new current address and count values, terminal-count events and the temporary byte through a small update port.

Top module: `dma_regfile`

## Requirements
- R1: After synchronous reset, all mask bits are 1, and the command, request, terminal-count and temporary registers are 0. The byte pointer selects the low byte. A status read returns 0 while no hardware request is active.
- R2: A write to offset 2n loads channel n's address word and a write to offset 2n+1 loads its count word (n = 0..3). Each write stores one byte into both the base and current copies: the low byte (bits 7:0) when the pointer is clear and the high byte (bits 15:8) when it is set.
- R3: Every read or write at offsets 0 to 7 toggles the single shared byte pointer. A write to offset C returns it to the low byte.
- R4: A read at offsets 0 to 7 returns, during the strobe, the byte of the current copy that the pointer selects.
- R5: A transfer update (upd_valid with channel upd_chan) replaces that channel's current address and count and leaves both base copies unchanged. If a bus write hits the same word in the same cycle, the bus write wins and the update is dropped for that word.
- R6: A write to offset 8 loads the command register. A read at offset 8 returns status, not the command.
- R7: The status byte carries the terminal-count flags in bits 3:0 and the pending requests (hardware request OR software request) in bits 7:4. An update with upd_tc sets the flag of its channel. A status read clears all flags, except that a flag set in the same cycle survives.
- R8: A write to offset 9 sets or clears the software request of the channel in data bits 1:0, taking the value from data bit 2.
- R9: A write to offset A sets or clears one mask bit using the same encoding as R8. A write to offset E clears all mask bits. A write to offset F loads all four mask bits from data bits 3:0.
- R10: A write to offset B stores data bits 7:2 as the mode field of the channel in data bits 1:0. The other channels' mode fields are left unchanged.
- R11: tmp_load captures tmp_data into the temporary register, and a read at offset D returns it.
- R12: A write to offset D performs a master clear. It zeroes the command, request, terminal-count and temporary registers, sets all mask bits and clears the byte pointer. It keeps the address, count and mode registers.
- R13: A read at offsets 9, A, B, C, E or F returns 0 and leaves the byte pointer unchanged. rdata is 0 whenever no read is selected. Strobes without chip select change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the read strobe |
| dreq | input | 4 | Hardware request lines, shown in status |
| upd_valid | input | 1 | Transfer update strobe |
| upd_chan | input | 2 | Channel of the update |
| upd_addr | input | 16 | New current address |
| upd_cnt | input | 16 | New current count |
| upd_tc | input | 1 | Update marks terminal count |
| tmp_load | input | 1 | Load temporary register |
| tmp_data | input | 8 | Temporary register data |
| base_addr | output | 64 | Base address, 16 bits per channel, channel 0 lowest |
| cur_addr | output | 64 | Current address per channel |
| base_cnt | output | 64 | Base count per channel |
| cur_cnt | output | 64 | Current count per channel |
| command | output | 8 | Command register |
| mode | output | 24 | Mode field, 6 bits per channel |
| mask | output | 4 | Mask bits |
| sw_req | output | 4 | Software request bits |
| byte_hi | output | 1 | Byte pointer, 1 selects the high byte |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit words and an 8-bit bus. With this build, every offset of the 4-bit map is a real register or strobe, so each address, count and command offset is driven. The full byte sequence of each word can be written and read back through the pointer. This build also allows the collision of a bus write with a transfer update on the same word, and a status read racing a new terminal count.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;

    localparam int DMA_NCH    = 4;
    localparam int DMA_REG_W  = 16;
    localparam int DMA_BYTE_W = 8;
    localparam int DMA_OFS_W  = 4;
    localparam int DMA_CHW    = $clog2(DMA_NCH);
    localparam int DMA_MODE_W = DMA_BYTE_W - DMA_CHW;

    // Control offsets above the channel word area
    typedef enum logic [DMA_OFS_W-1:0] {
        OFS_CMD_STAT  = 4'h8,
        OFS_SW_REQ    = 4'h9,
        OFS_MASK_ONE  = 4'hA,
        OFS_MODE      = 4'hB,
        OFS_PTR_CLR   = 4'hC,
        OFS_TMP_MCLR  = 4'hD,
        OFS_MASK_NONE = 4'hE,
        OFS_MASK_ALL  = 4'hF
    } ctl_ofs_e;

    // Per-channel mode field, written from data bits 7:2
    typedef struct packed {
        logic [1:0] xfer_kind;
        logic       step_down;
        logic       reload;
        logic [1:0] dir;
    } mode_fields_t;

    // Strobes consumed by the control register group
    typedef struct packed {
        logic cmd_wr;
        logic stat_rd;
        logic req_wr;
        logic mask1_wr;
        logic mode_wr;
        logic mclr;
        logic mask_clr;
        logic mask_all_wr;
    } ctl_op_t;

    // Full bus decode
    typedef struct packed {
        logic               ch_acc;
        logic               ch_wr;
        logic [DMA_CHW-1:0] ch;
        logic               is_cnt;
        logic               ptr_clr;
        logic               tmp_rd;
        ctl_op_t            op;
    } bus_dec_t;

    function automatic logic [DMA_CHW-1:0] chan_field(input logic [DMA_BYTE_W-1:0] b);
        return b[DMA_CHW-1:0];
    endfunction

    function automatic logic set_field(input logic [DMA_BYTE_W-1:0] b);
        return b[DMA_CHW];
    endfunction

    function automatic bus_dec_t bus_decode(input logic cs, input logic rd, input logic wr,
                                            input logic [DMA_OFS_W-1:0] ofs);
        bus_dec_t d;
        d        = '0;
        d.ch     = ofs[DMA_CHW:1];
        d.is_cnt = ofs[0];
        if (cs && (rd || wr)) begin
            if (!ofs[DMA_OFS_W-1]) begin
                d.ch_acc = 1'b1;
                d.ch_wr  = wr;
            end else if (wr) begin
                case (ctl_ofs_e'(ofs))
                    OFS_CMD_STAT:  d.op.cmd_wr      = 1'b1;
                    OFS_SW_REQ:    d.op.req_wr      = 1'b1;
                    OFS_MASK_ONE:  d.op.mask1_wr    = 1'b1;
                    OFS_MODE:      d.op.mode_wr     = 1'b1;
                    OFS_PTR_CLR:   d.ptr_clr        = 1'b1;
                    OFS_TMP_MCLR:  d.op.mclr        = 1'b1;
                    OFS_MASK_NONE: d.op.mask_clr    = 1'b1;
                    OFS_MASK_ALL:  d.op.mask_all_wr = 1'b1;
                    default:       d                = d;
                endcase
            end else begin
                d.op.stat_rd = (ctl_ofs_e'(ofs) == OFS_CMD_STAT);
                d.tmp_rd     = (ctl_ofs_e'(ofs) == OFS_TMP_MCLR);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    input  logic clear,
    output logic ptr_q
);

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= 1'b0;
        else if (clear)  ptr_q <= 1'b0;
        else if (toggle) ptr_q <= ~ptr_q;
    end

    // R3
    ptr_flip_chk: assert property (@(posedge clk) disable iff (rst)
        toggle && !clear |=> ptr_q != $past(ptr_q));

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !ptr_q);

endmodule

// File: rtl/dma_word_pair.sv
module dma_word_pair #(
    parameter int REG_W  = dma_reg_pkg::DMA_REG_W,
    parameter int BYTE_W = dma_reg_pkg::DMA_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              upd_en,
    input  logic [REG_W-1:0]  upd_val,
    output logic [REG_W-1:0]  base_q,
    output logic [REG_W-1:0]  cur_q
);

    localparam int LANES = REG_W / BYTE_W;

    logic [$clog2(LANES)-1:0] lane;
    assign lane = hi_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (wr_en) begin
            base_q[int'(lane)*BYTE_W +: BYTE_W] <= wdata;
            cur_q[int'(lane)*BYTE_W +: BYTE_W]  <= wdata;
        end else if (upd_en) begin
            cur_q <= upd_val;
        end
    end

    // R5
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(base_q));

    // R5
    cur_update_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !wr_en |=> cur_q == $past(upd_val));

    // R2
    low_lane_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && !hi_sel |=> base_q[BYTE_W-1:0] == $past(wdata) && cur_q[BYTE_W-1:0] == $past(wdata));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_reg_pkg::*;
#(
    parameter int NCH    = DMA_NCH,
    parameter int BYTE_W = DMA_BYTE_W,
    parameter int CHW    = $clog2(NCH),
    parameter int MODE_W = BYTE_W - CHW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ctl_op_t               op,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic [NCH-1:0]        dreq,
    input  logic [NCH-1:0]        tc_set,
    input  logic                  tmp_load,
    input  logic [BYTE_W-1:0]     tmp_data,
    output logic [BYTE_W-1:0]     cmd_q,
    output logic [NCH*MODE_W-1:0] mode_flat,
    output logic [NCH-1:0]        mask_q,
    output logic [NCH-1:0]        req_q,
    output logic [2*NCH-1:0]      status,
    output logic [BYTE_W-1:0]     tmp_q
);

    logic [NCH-1:0] tc_q;

    assign status = {dreq | req_q, tc_q};

    always_ff @(posedge clk) begin
        if (rst || op.mclr) begin
            cmd_q  <= '0;
            req_q  <= '0;
            tc_q   <= '0;
            tmp_q  <= '0;
            mask_q <= '1;
        end else begin
            if (op.cmd_wr) cmd_q <= wdata;
            if (op.req_wr) req_q[chan_field(wdata)] <= set_field(wdata);
            if (op.mask1_wr)         mask_q[chan_field(wdata)] <= set_field(wdata);
            else if (op.mask_clr)    mask_q <= '0;
            else if (op.mask_all_wr) mask_q <= wdata[NCH-1:0];
            tc_q <= (op.stat_rd ? '0 : tc_q) | tc_set;
            if (tmp_load) tmp_q <= tmp_data;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_mode
        mode_fields_t m_q;
        always_ff @(posedge clk) begin
            if (rst)
                m_q <= '0;
            else if (op.mode_wr && chan_field(wdata) == CHW'(c))
                m_q <= mode_fields_t'(wdata[BYTE_W-1:CHW]);
        end
        assign mode_flat[c*MODE_W +: MODE_W] = m_q;
    end

    // R7
    tc_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        op.stat_rd && tc_set == '0 |=> status[NCH-1:0] == '0);

    // R12
    mclr_regs_chk: assert property (@(posedge clk) disable iff (rst)
        op.mclr |=> cmd_q == '0 && req_q == '0 && tmp_q == '0 && &mask_q);

    // R9
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        op.mask_clr |=> mask_q == '0);

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_reg_pkg::*;
#(
    parameter int NCH    = DMA_NCH,
    parameter int REG_W  = DMA_REG_W,
    parameter int BYTE_W = DMA_BYTE_W,
    parameter int OFS_W  = DMA_OFS_W,
    parameter int CHW    = $clog2(NCH),
    parameter int MODE_W = BYTE_W - CHW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [OFS_W-1:0]      addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH-1:0]        dreq,
    input  logic                  upd_valid,
    input  logic [CHW-1:0]        upd_chan,
    input  logic [REG_W-1:0]      upd_addr,
    input  logic [REG_W-1:0]      upd_cnt,
    input  logic                  upd_tc,
    input  logic                  tmp_load,
    input  logic [BYTE_W-1:0]     tmp_data,
    output logic [NCH*REG_W-1:0]  base_addr,
    output logic [NCH*REG_W-1:0]  cur_addr,
    output logic [NCH*REG_W-1:0]  base_cnt,
    output logic [NCH*REG_W-1:0]  cur_cnt,
    output logic [BYTE_W-1:0]     command,
    output logic [NCH*MODE_W-1:0] mode,
    output logic [NCH-1:0]        mask,
    output logic [NCH-1:0]        sw_req,
    output logic                  byte_hi
);

    localparam int WORDS = 2 * NCH;

    bus_dec_t              dec;
    logic [NCH-1:0]        tc_set;
    logic [2*NCH-1:0]      status;
    logic [BYTE_W-1:0]     tmp_q;
    logic [REG_W-1:0]      word_base [WORDS];
    logic [REG_W-1:0]      word_cur  [WORDS];

    assign dec = bus_decode(cs, rd, wr, addr);

    dma_byte_ptr i_ptr (
        .clk    (clk),
        .rst    (rst),
        .toggle (dec.ch_acc),
        .clear  (dec.ptr_clr || dec.op.mclr),
        .ptr_q  (byte_hi)
    );

    always_comb begin
        tc_set = '0;
        if (upd_valid && upd_tc) tc_set[upd_chan] = 1'b1;
    end

    // Word index w = 2*channel + (count ? 1 : 0)
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int CH = w / 2;
        logic             wr_hit;
        logic [REG_W-1:0] upd_v;
        assign wr_hit = dec.ch_wr && dec.ch == CHW'(CH) && dec.is_cnt == 1'((w % 2));
        if (w % 2 == 1) begin : g_cnt
            assign upd_v = upd_cnt;
        end else begin : g_adr
            assign upd_v = upd_addr;
        end
        dma_word_pair #(.REG_W(REG_W), .BYTE_W(BYTE_W)) i_pair (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_hit),
            .hi_sel  (byte_hi),
            .wdata   (wdata),
            .upd_en  (upd_valid && upd_chan == CHW'(CH)),
            .upd_val (upd_v),
            .base_q  (word_base[w]),
            .cur_q   (word_cur[w])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign base_addr[c*REG_W +: REG_W] = word_base[2*c];
        assign cur_addr[c*REG_W +: REG_W]  = word_cur[2*c];
        assign base_cnt[c*REG_W +: REG_W]  = word_base[2*c+1];
        assign cur_cnt[c*REG_W +: REG_W]   = word_cur[2*c+1];
    end

    dma_ctrl_regs #(.NCH(NCH), .BYTE_W(BYTE_W), .CHW(CHW), .MODE_W(MODE_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op        (dec.op),
        .wdata     (wdata),
        .dreq      (dreq),
        .tc_set    (tc_set),
        .tmp_load  (tmp_load),
        .tmp_data  (tmp_data),
        .cmd_q     (command),
        .mode_flat (mode),
        .mask_q    (mask),
        .req_q     (sw_req),
        .status    (status),
        .tmp_q     (tmp_q)
    );

    always_comb begin
        rdata = '0;
        if (dec.ch_acc && !dec.ch_wr)
            rdata = word_cur[{dec.ch, dec.is_cnt}][int'(byte_hi)*BYTE_W +: BYTE_W];
        else if (dec.op.stat_rd)
            rdata = status;
        else if (dec.tmp_rd)
            rdata = tmp_q;
    end

    // R13
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |-> rdata == '0);

    // R13
    no_cs_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        !cs |=> $stable(byte_hi));

endmodule

// File: tb/test_dma_regfile.sv
module test_dma_regfile;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs, rd, wr;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [3:0]  dreq;
    logic        upd_valid;
    logic [1:0]  upd_chan;
    logic [15:0] upd_addr, upd_cnt;
    logic        upd_tc;
    logic        tmp_load;
    logic [7:0]  tmp_data;
    logic [63:0] base_addr, cur_addr, base_cnt, cur_cnt;
    logic [7:0]  command;
    logic [23:0] mode;
    logic [3:0]  mask, sw_req;
    logic        byte_hi;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    dma_regfile i_dma_regfile (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dreq(dreq), .upd_valid(upd_valid),
        .upd_chan(upd_chan), .upd_addr(upd_addr), .upd_cnt(upd_cnt),
        .upd_tc(upd_tc), .tmp_load(tmp_load), .tmp_data(tmp_data),
        .base_addr(base_addr), .cur_addr(cur_addr), .base_cnt(base_cnt),
        .cur_cnt(cur_cnt), .command(command), .mode(mode), .mask(mask),
        .sw_req(sw_req), .byte_hi(byte_hi)
    );

    function automatic logic [15:0] w16(input logic [63:0] v, input int i);
        return v[i*16 +: 16];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = ofs; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] ofs, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = ofs;
        #(CLK_NS/4);
        d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic xfer_upd(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] c,
                            input logic tc);
        @(negedge clk);
        upd_valid = 1'b1; upd_chan = ch; upd_addr = a; upd_cnt = c; upd_tc = tc;
        @(negedge clk);
        upd_valid = 1'b0; upd_tc = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 mask after reset", mask, 4'hF);
        check("R1 command after reset", command, 8'h00);
        check("R1 sw_req after reset", sw_req, 4'h0);
        check("R1 pointer after reset", byte_hi, 1'b0);
        bus_rd(4'h8, d);
        check("R1 status after reset", d, 8'h00);
        bus_rd(4'hD, d);
        check("R1 temp after reset", d, 8'h00);
    endtask

    task automatic t_program;
        for (int n = 0; n < 4; n++) begin
            bus_wr(4'(2*n), 8'(8'h20 + n));
            bus_wr(4'(2*n), 8'(8'h10 + n));
            bus_wr(4'(2*n+1), 8'(8'h40 + n));
            bus_wr(4'(2*n+1), 8'(8'h30 + n));
        end
        for (int n = 0; n < 4; n++) begin
            check("R2 base addr", w16(base_addr, n), {8'(8'h10 + n), 8'(8'h20 + n)});
            check("R2 cur addr", w16(cur_addr, n), {8'(8'h10 + n), 8'(8'h20 + n)});
            check("R2 base cnt", w16(base_cnt, n), {8'(8'h30 + n), 8'(8'h40 + n)});
            check("R2 cur cnt", w16(cur_cnt, n), {8'(8'h30 + n), 8'(8'h40 + n)});
        end
        check("R3 pointer after pairs", byte_hi, 1'b0);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        bus_rd(4'h4, d);
        check("R4 ch2 addr low", d, 8'h22);
        check("R3 pointer after read", byte_hi, 1'b1);
        bus_rd(4'h4, d);
        check("R4 ch2 addr high", d, 8'h12);
        bus_rd(4'h7, d);
        check("R4 ch3 count low", d, 8'h43);
        bus_wr(4'hC, 8'h00);
        check("R3 pointer cleared by offset C", byte_hi, 1'b0);
        bus_wr(4'h6, 8'hEE);
        bus_wr(4'hC, 8'h00);
        bus_wr(4'h6, 8'h99);
        check("R3 clear makes next write low byte", w16(cur_addr, 3), 16'h1399);
        bus_wr(4'hC, 8'h00);
    endtask

    task automatic t_transfer;
        xfer_upd(2'd1, 16'h5566, 16'h0777, 1'b0);
        check("R5 cur addr updated", w16(cur_addr, 1), 16'h5566);
        check("R5 base addr kept", w16(base_addr, 1), 16'h1121);
        check("R5 cur cnt updated", w16(cur_cnt, 1), 16'h0777);
        check("R5 base cnt kept", w16(base_cnt, 1), 16'h3141);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = 4'h2; wdata = 8'h77;
        upd_valid = 1'b1; upd_chan = 2'd1; upd_addr = 16'hAAAA; upd_cnt = 16'h0BBB;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; upd_valid = 1'b0;
        check("R5 bus write wins cur addr", w16(cur_addr, 1), 16'h5577);
        check("R5 bus write base addr", w16(base_addr, 1), 16'h1177);
        check("R5 other word still updated", w16(cur_cnt, 1), 16'h0BBB);
        bus_wr(4'hC, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] d;
        dreq = 4'b0001;
        xfer_upd(2'd2, 16'h1222, 16'h3242, 1'b1);
        bus_wr(4'h9, 8'h07);
        check("R8 software request ch3 set", sw_req, 4'b1000);
        bus_rd(4'h8, d);
        check("R7 status with tc and requests", d, 8'h94);
        bus_rd(4'h8, d);
        check("R7 tc cleared after status read", d, 8'h90);
        bus_wr(4'h9, 8'h03);
        check("R8 software request ch3 cleared", sw_req, 4'b0000);
        bus_rd(4'h8, d);
        check("R7 status hardware request only", d, 8'h10);
        dreq = 4'b0000;
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = 4'h8;
        upd_valid = 1'b1; upd_chan = 2'd0; upd_addr = 16'h1020; upd_cnt = 16'h3040; upd_tc = 1'b1;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; upd_valid = 1'b0; upd_tc = 1'b0;
        bus_rd(4'h8, d);
        check("R7 tc set during read survives", d, 8'h01);
    endtask

    task automatic t_cmd;
        logic [7:0] d;
        bus_wr(4'h8, 8'h03);
        check("R6 command written", command, 8'h03);
        bus_rd(4'h8, d);
        check("R6 offset 8 read is status", d, 8'h00);
    endtask

    task automatic t_mask;
        bus_wr(4'hA, 8'h01);
        check("R9 single mask clear ch1", mask, 4'b1101);
        bus_wr(4'hA, 8'h05);
        check("R9 single mask set ch1", mask, 4'b1111);
        bus_wr(4'hE, 8'hFF);
        check("R9 clear all masks", mask, 4'b0000);
        bus_wr(4'hF, 8'h5A);
        check("R9 load all masks", mask, 4'hA);
    endtask

    task automatic t_mode;
        bus_wr(4'hB, 8'hAE);
        check("R10 mode ch2", mode[17:12], 6'h2B);
        check("R10 mode ch0 untouched", mode[5:0], 6'h00);
        bus_wr(4'hB, 8'h41);
        check("R10 mode ch1", mode[11:6], 6'h10);
        check("R10 mode ch2 kept", mode[17:12], 6'h2B);
    endtask

    task automatic t_temp;
        logic [7:0] d;
        @(negedge clk);
        tmp_load = 1'b1; tmp_data = 8'h3C;
        @(negedge clk);
        tmp_load = 1'b0;
        bus_rd(4'hD, d);
        check("R11 temporary readback", d, 8'h3C);
    endtask

    task automatic t_mclr;
        logic [7:0] d;
        bus_wr(4'h9, 8'h04);
        xfer_upd(2'd0, 16'h1020, 16'h3040, 1'b1);
        bus_rd(4'h0, d);
        check("R12 pointer set before clear", byte_hi, 1'b1);
        bus_wr(4'hD, 8'h00);
        check("R12 command zeroed", command, 8'h00);
        check("R12 masks set", mask, 4'hF);
        check("R12 requests zeroed", sw_req, 4'h0);
        check("R12 pointer cleared", byte_hi, 1'b0);
        bus_rd(4'hD, d);
        check("R12 temporary zeroed", d, 8'h00);
        bus_rd(4'h8, d);
        check("R12 status zeroed", d, 8'h00);
        check("R12 base address kept", w16(base_addr, 0), 16'h1020);
        check("R12 mode kept", mode[17:12], 6'h2B);
    endtask

    task automatic t_misc;
        logic [7:0] d;
        logic [3:0] wo [6] = '{4'h9, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF};
        for (int i = 0; i < 6; i++) begin
            bus_rd(wo[i], d);
            check("R13 write-only offset reads zero", d, 8'h00);
        end
        check("R13 pointer unchanged by those reads", byte_hi, 1'b0);
        @(negedge clk);
        cs = 1'b0; wr = 1'b1; addr = 4'h8; wdata = 8'hFF;
        @(negedge clk);
        addr = 4'h0; wdata = 8'h55;
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = 4'hD;
        #(CLK_NS/4);
        check("R13 rdata zero without cs", rdata, 8'h00);
        @(negedge clk);
        rd = 1'b0;
        check("R13 command unchanged without cs", command, 8'h00);
        check("R13 address unchanged without cs", w16(base_addr, 0), 16'h1020);
        check("R13 pointer unchanged without cs", byte_hi, 1'b0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        dreq = '0; upd_valid = 1'b0; upd_chan = '0; upd_addr = '0; upd_cnt = '0;
        upd_tc = 1'b0; tmp_load = 1'b0; tmp_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_program;
        t_readback;
        t_transfer;
        t_status;
        t_cmd;
        t_mask;
        t_mode;
        t_temp;
        t_mclr;
        t_misc;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule